// File: doc/BRIEF.md
# Von Neumann Bit Debiaser

This block removes bias from a stream of raw random bits. Each raw bit arrives on a single-bit data input and is taken only in a cycle where its valid strobe is high. Any number of idle cycles may separate valid bits. The block splits the accepted bits into consecutive pairs that do not overlap. For each pair it emits at most one bit, together with a one-cycle output strobe.

A pair of two equal bits gives no output. A pair of two different bits gives one output bit, and that bit equals the second bit of the pair. So 1 followed by 0 gives 0, and 0 followed by 1 gives 1. If the input bits are independent, the output bits are unbiased, whatever the bias of the source. The output rate is variable and always lower than the input rate. A consumer must therefore qualify each output bit with the output strobe.

Internally, a two-state controller tracks whether the first bit of a pair is being held. It drives a small datapath through a struct of strobes. The datapath keeps the held bit and registers the output.

Top module: `vn_debiaser`

## Requirements
- R1: While rstN is low, outValid is 0 and outBit is 0. The first valid bit accepted after reset is treated as the first bit of a new pair.
- R2: A pair whose first bit is 1 and whose second bit is 0 produces outBit = 0 with outValid = 1.
- R3: A pair whose first bit is 0 and whose second bit is 1 produces outBit = 1 with outValid = 1.
- R4: A pair of two 0s or two 1s produces no output, and outValid stays 0.
- R5: outValid is a registered pulse exactly one cycle long. It is high in the cycle after the clock edge that samples the second bit of an unequal pair.
- R6: rawBit is ignored in cycles where rawValid is low. The held first bit and the pair state are kept across any number of such idle cycles, so outValid stays 0 during them.
- R7: Pairs do not overlap. After the second bit of a pair is sampled, the next valid bit starts a new pair, whether or not a bit was emitted.
- R8: A first bit held when reset is asserted is discarded.
- R9: outBit keeps its last emitted value until the next emission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| rawBit | input | 1 | Raw input bit |
| rawValid | input | 1 | rawBit is valid this cycle |
| outBit | output | 1 | Debiased output bit |
| outValid | output | 1 | One-cycle pulse marking a new outBit |

## Verification
The bench covers all four pair values, each sent both on back-to-back cycles and with long idle gaps. During the gaps, rawBit toggles while rawValid is low. A design that sampled rawBit without its strobe would then form the wrong pairs, or would emit during the gaps.

A stream of 0, 0, 1, 0 tells apart pairing with and without overlap. A sliding-window design would emit a 1 at the third bit, where only a 0 is expected at the fourth. Asserting reset while a 1 is held, then sending 0 and 1, shows whether the held bit leaked through reset: that would give an emitted 0 instead of a 1.

Idle cycles after each emission and after each discarded pair catch a strobe wider than one cycle, or an outBit that changes without a strobe.

// File: rtl/vnd_pkg.sv
package vnd_pkg;

  typedef enum logic {
    PAIR_WAIT = 1'b0,
    PAIR_HOLD = 1'b1
  } pairState_t;

  typedef struct packed {
    logic loadFirst;
    logic pairDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/vnd_ctrl.sv
module vnd_ctrl
  import vnd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawValid,
  output ctrlStrobes_t strobes
);

  pairState_t state;
  pairState_t stateNext;

  always_comb begin
    stateNext         = state;
    strobes.loadFirst = 1'b0;
    strobes.pairDone  = 1'b0;
    if (rawValid) begin
      if (state == PAIR_WAIT) begin
        strobes.loadFirst = 1'b1;
        stateNext         = PAIR_HOLD;
      end else begin
        strobes.pairDone  = 1'b1;
        stateNext         = PAIR_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PAIR_WAIT;
    else       state <= stateNext;
  end

  // R6: idle cycles leave the pair state untouched
  p_idle_keeps_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |=> $stable(state));

  // R7: a completed pair always returns to waiting for a fresh first bit
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PAIR_HOLD && rawValid) |=> state == PAIR_WAIT);

  // R7: a first bit is always followed by holding
  p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PAIR_WAIT && rawValid) |=> state == PAIR_HOLD);

endmodule

// File: rtl/vnd_datapath.sv
module vnd_datapath
  import vnd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawBit,
  input  ctrlStrobes_t strobes,
  output logic         outBit,
  output logic         outValid
);

  logic heldBit;
  logic pairDiffers;

  assign pairDiffers = strobes.pairDone && (heldBit != rawBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBit  <= 1'b0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (strobes.loadFirst) heldBit <= rawBit;
      outValid <= pairDiffers;
      if (pairDiffers) outBit <= rawBit;
    end
  end

  // R2: 1 then 0 yields an emitted 0
  p_one_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pairDone && heldBit && !rawBit) |=> (outValid && !outBit));

  // R3: 0 then 1 yields an emitted 1
  p_zero_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pairDone && !heldBit && rawBit) |=> (outValid && outBit));

  // R4: equal pairs are dropped
  p_equal_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pairDone && (heldBit == rawBit)) |=> !outValid);

  // R5: the output strobe never lasts two cycles
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9: the output bit only moves together with a strobe
  p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outBit));

  // R1: no strobe without a completed pair
  p_strobe_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pairDone |=> !outValid);

endmodule

// File: rtl/vn_debiaser.sv
module vn_debiaser
  import vnd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rawBit,
  input  logic rawValid,
  output logic outBit,
  output logic outValid
);

  ctrlStrobes_t strobes;

  vnd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rawValid (rawValid),
    .strobes  (strobes)
  );

  vnd_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .rawBit   (rawBit),
    .strobes  (strobes),
    .outBit   (outBit),
    .outValid (outValid)
  );

endmodule

// File: tb/tb_vn_debiaser.sv
`timescale 1ns/1ps
module tb_vn_debiaser;

  localparam int HALF_NS   = 4;
  localparam int NUM_VEC   = 10;
  localparam int WATCHDOG  = 50000;

  // entry: [7] first bit, [6] second bit, [5:0] idle cycles between them
  localparam logic [7:0] VEC [NUM_VEC] = '{
    8'b10_000000, 8'b01_000000, 8'b00_000000, 8'b11_000000,
    8'b10_001010, 8'b01_001010, 8'b00_001010, 8'b11_001010,
    8'b01_111111, 8'b10_000001
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawBit = 1'b0;
  logic rawValid = 1'b0;
  logic outBit;
  logic outValid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic lastOut = 1'b0;

  vn_debiaser dut (
    .clk      (clk),
    .rstN     (rstN),
    .rawBit   (rawBit),
    .rawValid (rawValid),
    .outBit   (outBit),
    .outValid (outValid)
  );

  always #HALF_NS clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // drive one valid bit; returns at the next negedge, after the sampling edge
  task automatic sendBit(input logic b);
    rawBit = b;
    rawValid = 1'b1;
    @(negedge clk);
    rawValid = 1'b0;
  endtask

  // idle cycles with toggling data that must be ignored (R6)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rawBit = ~rawBit;
      @(negedge clk);
      chk("R6", outValid, 1'b0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", outValid, 1'b0);
    chk("R1 bit", outBit, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after", outValid, 1'b0);

    // table walk
    for (int v = 0; v < NUM_VEC; v++) begin
      logic a, b, differs;
      int gap;
      a = VEC[v][7];
      b = VEC[v][6];
      gap = int'(VEC[v][5:0]);
      differs = (a != b);
      sendBit(a);
      chk("R7 first", outValid, 1'b0);
      idle(gap);
      sendBit(b);
      if (!differs)    chk("R4", outValid, 1'b0);
      else if (a)      chk("R2", outValid, 1'b1);
      else             chk("R3", outValid, 1'b1);
      if (differs) begin
        chk(a ? "R2 value" : "R3 value", outBit, b);
        lastOut = b;
      end else begin
        chk("R9 after drop", outBit, lastOut);
      end
      idle(1);
      chk("R5 pulse end", outValid, 1'b0);
      idle(2);
      chk("R9 hold", outBit, lastOut);
    end

    // R7: stream 0,0,1,0 -> only one emission of 0 at the fourth bit
    sendBit(1'b0); chk("R7 b1", outValid, 1'b0);
    sendBit(1'b0); chk("R7 b2", outValid, 1'b0);
    sendBit(1'b1); chk("R7 b3", outValid, 1'b0);
    sendBit(1'b0); chk("R7 b4", outValid, 1'b1);
    chk("R7 value", outBit, 1'b0);
    lastOut = 1'b0;
    idle(1);
    chk("R5 back-to-back", outValid, 1'b0);

    // R8: hold a 1, reset, then send 0,1 -> must emit 1
    sendBit(1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid", outValid, 1'b0);
    chk("R1 mid bit", outBit, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    sendBit(1'b0);
    chk("R8 first", outValid, 1'b0);
    sendBit(1'b1);
    chk("R8 valid", outValid, 1'b1);
    chk("R8 value", outBit, 1'b1);
    lastOut = 1'b1;

    // R9: equal pair after an emission keeps the old value
    sendBit(1'b0);
    sendBit(1'b0);
    chk("R4 tail", outValid, 1'b0);
    idle(4);
    chk("R9 tail", outBit, lastOut);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule